// File: doc/BRIEF.md
# Calendar Time Keeper with Alarm

This block holds a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. One strobe per second moves the calendar forward. The block presents each field in binary or in packed BCD, and the hour in 24-hour form or in 12-hour form, as its mode inputs select. An update-in-progress flag is raised for a fixed window after each accepted strobe. At the end of that window the new time is copied to the presented fields. The time is then compared with three alarm bytes, and one-cycle flag codes are sent out. Those codes are meant to be ORed into a status register that is kept elsewhere.

A host port outside this block writes the presented fields by index. While the freeze input is low, a write takes effect in the running calendar one cycle later. While the freeze input is high, the presented fields are held. The host can then write a full new time, and it is loaded into the calendar on the cycle after the freeze input is released.

Top module: `cal_clock`

## Requirements
- R1: An accepted strobe advances the time by one second. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each hour wrap also steps the day of week, which wraps from 6 to 0.
- R2: On a day wrap, the month length is 31,28,31,30,31,30,31,31,30,31,30,31 for months 1 to 12. February has 29 days when the year value is divisible by 4 (full year 2000+yy). Any other month value counts 31 days. Past the last day the month steps; above 12 it becomes 1 and the year steps, wrapping 99 to 0.
- R3: With bin_mode_i=1 every field is plain binary. With bin_mode_i=0 every field is BCD, tens in bits 7:4 and units in bits 3:0. The same rule applies when host-written fields and alarm bytes are decoded.
- R4: With h24_i=1 the hour field shows 0 to 23. With h24_i=0 it shows hour mod 12, with bit 7 set for hours 12 to 23. On load in 12-hour form, bit 7 adds 12 to the value in bits 6:0.
- R5: A strobe is accepted only when osc_sel_i equals 3'b010. Otherwise it is skipped: no advance, no uip_o, no flags, and the fields are unchanged.
- R6: uip_o rises on the edge that accepts a strobe if set_i is low. It stays high for UPD_CYC cycles and falls on the end-of-update edge. It is forced low while set_i is high.
- R7: The presented fields take the new time on the edge UPD_CYC cycles after the accepting edge, unless set_i is high on that edge. While set_i is high, only host writes change them. After reset the fields read sec/min/hour/wday/year 0 and mday/mon 1.
- R8: wr_idx_i selects 0 sec, 1 min, 2 hour, 3 wday, 4 mday, 5 mon, 6 year; 7 is ignored. A write with set_i low loads the decoded fields into the calendar one edge later. With set_i high, the load happens one edge after set_i falls.
- R9: An alarm hit occurs when seconds, minutes and hours each either have bits 7:6 = 2'b11 or decode to the calendar value. The hours alarm byte is decoded without the bit-7 rule and is compared with the 0 to 23 hour.
- R10: On the end-of-update edge, flags_o shows 8'hA0 for an alarm hit when alm_en_i is set, ORed with 8'h90 when upd_en_i is set. This happens even while set_i is high. flags_o is otherwise 0. irq_o is high exactly when flags_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe |
| osc_sel_i | input | 3 | Divider field; 3'b010 lets time run |
| bin_mode_i | input | 1 | 1 binary, 0 BCD |
| h24_i | input | 1 | 1 24-hour, 0 12-hour with PM bit |
| set_i | input | 1 | Freeze presented fields for host load |
| alm_en_i | input | 1 | Alarm flag enable |
| upd_en_i | input | 1 | Update-ended flag enable |
| wr_en_i | input | 1 | Host field write strobe |
| wr_idx_i | input | 3 | Field index of the write |
| wr_data_i | input | 8 | Write data, encoded |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hour_i | input | 8 | Hours alarm byte |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| wday_o | output | 8 | Day of week field |
| mday_o | output | 8 | Day of month field |
| mon_o | output | 8 | Month field |
| year_o | output | 8 | Year field |
| uip_o | output | 1 | Update in progress |
| flags_o | output | 8 | One-cycle status flag codes |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume strobes arrive no faster than one per update window. They also assume host writes and freeze changes do not fall on a strobe edge or an end-of-update edge. The bench drives each strobe as a single cycle and waits out the full window before its next action. Writes and the release of set_i are finished, including the one-cycle load, before the next strobe. Mode inputs change only while the calendar is idle. Random times are generated as valid calendar values, with the wrap points favoured, so the reference model and the block decode the same bytes.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [2:0] OSC_RUN  = 3'b010;
  localparam logic [7:0] FLAG_ALM = 8'hA0;
  localparam logic [7:0] FLAG_UPD = 8'h90;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_time_t;

  function automatic logic [7:0] dec_fld(logic [7:0] v, logic bin);
    return bin ? v : (({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]});
  endfunction

  function automatic logic [7:0] enc_fld(logic [7:0] v, logic bin);
    return bin ? v : {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] month_len(logic [7:0] mon, logic [7:0] year);
    logic leap;
    leap = (year[1:0] == 2'b00);
    case (mon)
      8'd2:                      return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_codec.sv
module cal_codec
  import cal_pkg::*;
(
  input  cal_time_t cnt_i,
  input  cal_time_t disp_i,
  input  logic      bin_i,
  input  logic      h24_i,
  output cal_time_t enc_o,
  output cal_time_t dec_o
);
  logic [7:0] h12;

  always_comb begin
    h12         = cnt_i.hour % 8'd12;
    enc_o.sec   = enc_fld(cnt_i.sec, bin_i);
    enc_o.min   = enc_fld(cnt_i.min, bin_i);
    enc_o.hour  = h24_i ? enc_fld(cnt_i.hour, bin_i)
                        : (enc_fld(h12, bin_i) | ((cnt_i.hour >= 8'd12) ? 8'h80 : 8'h00));
    enc_o.wday  = enc_fld(cnt_i.wday, bin_i);
    enc_o.mday  = enc_fld(cnt_i.mday, bin_i);
    enc_o.mon   = enc_fld(cnt_i.mon, bin_i);
    enc_o.year  = enc_fld(cnt_i.year, bin_i);
  end

  always_comb begin
    dec_o.sec  = dec_fld(disp_i.sec, bin_i);
    dec_o.min  = dec_fld(disp_i.min, bin_i);
    dec_o.hour = dec_fld({1'b0, disp_i.hour[6:0]}, bin_i)
               + ((!h24_i && disp_i.hour[7]) ? 8'd12 : 8'd0);
    dec_o.wday = dec_fld(disp_i.wday, bin_i);
    dec_o.mday = dec_fld(disp_i.mday, bin_i);
    dec_o.mon  = dec_fld(disp_i.mon, bin_i);
    dec_o.year = dec_fld(disp_i.year, bin_i);
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      adv_i,
  input  cal_time_t load_val_i,
  output cal_time_t time_o
);
  cal_time_t cur_q, nxt;
  logic [7:0] mlen;

  assign mlen   = month_len(cur_q.mon, cur_q.year);
  assign time_o = cur_q;

  always_comb begin
    nxt = cur_q;
    if (cur_q.sec >= 8'd59) begin
      nxt.sec = '0;
      if (cur_q.min >= 8'd59) begin
        nxt.min = '0;
        if (cur_q.hour >= 8'd23) begin
          nxt.hour = '0;
          nxt.wday = (cur_q.wday >= 8'd6) ? 8'd0 : cur_q.wday + 8'd1;
          if (cur_q.mday >= mlen) begin
            nxt.mday = 8'd1;
            if (cur_q.mon >= 8'd12) begin
              nxt.mon  = 8'd1;
              nxt.year = (cur_q.year >= 8'd99) ? 8'd0 : cur_q.year + 8'd1;
            end else begin
              nxt.mon = cur_q.mon + 8'd1;
            end
          end else begin
            nxt.mday = cur_q.mday + 8'd1;
          end
        end else begin
          nxt.hour = cur_q.hour + 8'd1;
        end
      end else begin
        nxt.min = cur_q.min + 8'd1;
      end
    end else begin
      nxt.sec = cur_q.sec + 8'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd0,
                 mday: 8'd1, mon: 8'd1, year: 8'd0};
    end else if (load_i) begin
      cur_q <= load_val_i;
    end else if (adv_i) begin
      cur_q <= nxt;
    end
  end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  cal_time_t  time_i,
  input  logic       bin_i,
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hour_i,
  output logic       hit_o
);
  logic [2:0]      match;
  logic [2:0][7:0] alm;
  logic [2:0][7:0] ref_val;

  assign alm     = {alm_hour_i, alm_min_i, alm_sec_i};
  assign ref_val = {time_i.hour, time_i.min, time_i.sec};

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign match[i] = (alm[i][7:6] == 2'b11) || (dec_fld(alm[i], bin_i) == ref_val[i]);
  end

  assign hit_o = &match;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int UPD_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] osc_sel_i,
  input  logic       bin_mode_i,
  input  logic       h24_i,
  input  logic       set_i,
  input  logic       alm_en_i,
  input  logic       upd_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hour_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic [7:0] flags_o,
  output logic       irq_o
);
  localparam int CW = $clog2(UPD_CYC + 1);

  cal_time_t cnt, disp_q, enc, dec;
  logic [CW-1:0] win_q;
  logic busy_q, uip_q, set_q, pend_q, irq_q, hit;
  logic [7:0] flags_q;
  logic start, upd_end;

  assign start   = tick_i && (osc_sel_i == OSC_RUN) && !busy_q;
  assign upd_end = busy_q && (win_q == CW'(1));

  cal_counter u_cnt (
    .clk_i, .rst_ni,
    .load_i     (pend_q),
    .adv_i      (start),
    .load_val_i (dec),
    .time_o     (cnt)
  );

  cal_codec u_codec (
    .cnt_i  (cnt),
    .disp_i (disp_q),
    .bin_i  (bin_mode_i),
    .h24_i  (h24_i),
    .enc_o  (enc),
    .dec_o  (dec)
  );

  cal_alarm u_alm (
    .time_i     (cnt),
    .bin_i      (bin_mode_i),
    .alm_sec_i, .alm_min_i, .alm_hour_i,
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      win_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      win_q  <= CW'(UPD_CYC);
    end else if (busy_q) begin
      busy_q <= !upd_end;
      win_q  <= win_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q <= 1'b0;
    end else if (set_i) begin
      uip_q <= 1'b0;
    end else if (start) begin
      uip_q <= 1'b1;
    end else if (upd_end) begin
      uip_q <= 1'b0;
    end
  end

  // copy first, host write wins on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd0,
                  mday: 8'd1, mon: 8'd1, year: 8'd0};
    end else begin
      if (upd_end && !set_i) disp_q <= enc;
      if (wr_en_i) begin
        case (wr_idx_i)
          3'd0:    disp_q.sec  <= wr_data_i;
          3'd1:    disp_q.min  <= wr_data_i;
          3'd2:    disp_q.hour <= wr_data_i;
          3'd3:    disp_q.wday <= wr_data_i;
          3'd4:    disp_q.mday <= wr_data_i;
          3'd5:    disp_q.mon  <= wr_data_i;
          3'd6:    disp_q.year <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q   <= 1'b0;
      pend_q  <= 1'b0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      set_q   <= set_i;
      pend_q  <= (wr_en_i && !set_i && (wr_idx_i != 3'd7)) || (set_q && !set_i);
      flags_q <= upd_end ? (((alm_en_i && hit) ? FLAG_ALM : 8'h00) |
                            (upd_en_i ? FLAG_UPD : 8'h00)) : 8'h00;
      irq_q   <= upd_end && ((alm_en_i && hit) || upd_en_i);
    end
  end

  assign sec_o   = disp_q.sec;
  assign min_o   = disp_q.min;
  assign hour_o  = disp_q.hour;
  assign wday_o  = disp_q.wday;
  assign mday_o  = disp_q.mday;
  assign mon_o   = disp_q.mon;
  assign year_o  = disp_q.year;
  assign uip_o   = uip_q;
  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [2:0] osc_sel_i,
  input logic       set_i,
  input logic       wr_en_i,
  input logic [55:0] fields,
  input logic       uip_o,
  input logic [7:0] flags_o,
  input logic       irq_o
);
  AST_UIP_LOW_IN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uip_o); // R6

  AST_GATE_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (osc_sel_i != OSC_RUN) && !uip_o) |=> !uip_o); // R5

  AST_FIELDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wr_en_i) |=> $stable(fields)); // R7

  AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == 8'h00) || (flags_o == FLAG_ALM) || (flags_o == FLAG_UPD) ||
    (flags_o == (FLAG_ALM | FLAG_UPD))); // R10

  AST_FLAG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o != 8'h00) |=> (flags_o == 8'h00)); // R10

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flags_o != 8'h00)); // R10
endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .osc_sel_i (osc_sel_i),
  .set_i     (set_i),
  .wr_en_i   (wr_en_i),
  .fields    ({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o}),
  .uip_o     (uip_o),
  .flags_o   (flags_o),
  .irq_o     (irq_o)
);

// File: tb/cal_clock_tb.sv
module cal_clock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UPD = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, bin = 0, h24 = 1, set = 0, alm_en = 0, upd_en = 0, wr_en = 0;
  logic [2:0] osc = 3'b010, wr_idx = 0;
  logic [7:0] wr_data = 0, a_sec = 8'hC0, a_min = 8'hC0, a_hour = 8'hC0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, flags_o;
  logic uip_o, irq_o;

  cal_clock #(.UPD_CYC(UPD)) u_dut (
    .clk_i(clk), .rst_ni, .tick_i(tick), .osc_sel_i(osc), .bin_mode_i(bin),
    .h24_i(h24), .set_i(set), .alm_en_i(alm_en), .upd_en_i(upd_en),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hour),
    .sec_o, .min_o, .hour_o, .wday_o, .mday_o, .mon_o, .year_o,
    .uip_o, .flags_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_t[7];
  logic [7:0] m_d[7];

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] f_enc(int v, bit b);
    return b ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int f_dec(logic [7:0] v, bit b);
    return b ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] f_enc_h(int h, bit b, bit t24);
    if (t24) return f_enc(h, b);
    return f_enc(h % 12, b) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction
  function automatic int f_dec_h(logic [7:0] v, bit b, bit t24);
    return f_dec({1'b0, v[6:0]}, b) + ((!t24 && v[7]) ? 12 : 0);
  endfunction
  function automatic int f_dim(int mon, int yr);
    case (mon)
      2: return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] m_enc_fld(int i);
    return (i == 2) ? f_enc_h(m_t[2], bin, h24) : f_enc(m_t[i], bin);
  endfunction

  task automatic m_load();
    for (int i = 0; i < 7; i++)
      m_t[i] = (i == 2) ? f_dec_h(m_d[2], bin, h24) : f_dec(m_d[i], bin);
  endtask

  task automatic m_adv();
    if (m_t[0] >= 59) begin
      m_t[0] = 0;
      if (m_t[1] >= 59) begin
        m_t[1] = 0;
        if (m_t[2] >= 23) begin
          m_t[2] = 0;
          m_t[3] = (m_t[3] >= 6) ? 0 : m_t[3] + 1;
          if (m_t[4] >= f_dim(m_t[5], m_t[6])) begin
            m_t[4] = 1;
            if (m_t[5] >= 12) begin
              m_t[5] = 1;
              m_t[6] = (m_t[6] >= 99) ? 0 : m_t[6] + 1;
            end else m_t[5]++;
          end else m_t[4]++;
        end else m_t[2]++;
      end else m_t[1]++;
    end else m_t[0]++;
  endtask

  function automatic logic [7:0] disp(int i);
    case (i)
      0: return sec_o;  1: return min_o;  2: return hour_o; 3: return wday_o;
      4: return mday_o; 5: return mon_o;  default: return year_o;
    endcase
  endfunction

  task automatic host_wr(int idx, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk); wr_en = 0;
    if (idx < 7) m_d[idx] = d;
    if (!set && idx < 7) m_load();
    @(negedge clk);
  endtask

  task automatic set_on();
    @(negedge clk); set = 1;
    @(negedge clk);
  endtask

  task automatic set_off();
    @(negedge clk); set = 0;
    @(negedge clk); @(negedge clk);
    m_load();
  endtask

  // load a full time in the current mode through the freeze path
  task automatic load_time(int s, int mi, int h, int wd, int md, int mo, int y);
    set_on();
    host_wr(0, f_enc(s, bin));  host_wr(1, f_enc(mi, bin));
    host_wr(2, f_enc_h(h, bin, h24)); host_wr(3, f_enc(wd, bin));
    host_wr(4, f_enc(md, bin)); host_wr(5, f_enc(mo, bin));
    host_wr(6, f_enc(y, bin));
    set_off();
  endtask

  task automatic do_tick(string req);
    bit gate, hit, exp_uip;
    logic [7:0] ef;
    gate = (osc == 3'b010);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    exp_uip = gate && !set;
    chk("R6", "uip after strobe", 8'(uip_o), 8'(exp_uip));
    if (gate) m_adv();
    repeat (UPD - 1) @(negedge clk);
    chk("R6", "uip before end", 8'(uip_o), 8'(exp_uip));
    chk("R7", "no early flags", flags_o, 8'h00);
    @(negedge clk);
    ef = 8'h00;
    if (gate) begin
      if (!set) for (int i = 0; i < 7; i++) m_d[i] = m_enc_fld(i);
      hit = (a_sec[7:6] == 2'b11 || f_dec(a_sec, bin) == m_t[0]) &&
            (a_min[7:6] == 2'b11 || f_dec(a_min, bin) == m_t[1]) &&
            (a_hour[7:6] == 2'b11 || f_dec(a_hour, bin) == m_t[2]);
      if (alm_en && hit) ef |= 8'hA0;
      if (upd_en) ef |= 8'h90;
    end
    chk("R10", "flags at end", flags_o, ef);
    chk("R10", "irq at end", 8'(irq_o), 8'(ef != 0));
    chk("R6", "uip after end", 8'(uip_o), 8'h00);
    for (int i = 0; i < 7; i++) chk(req, $sformatf("field %0d", i), disp(i), m_d[i]);
    @(negedge clk);
    chk("R10", "flags one cycle", flags_o, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240229));
    m_t = '{0, 0, 0, 0, 1, 1, 0};
    for (int i = 0; i < 7; i++) m_d[i] = 8'(m_t[i]);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R7 reset state
    chk("R7", "reset sec", sec_o, 8'h00);
    chk("R7", "reset mday", mday_o, 8'h01);
    chk("R7", "reset mon", mon_o, 8'h01);
    chk("R6", "reset uip", 8'(uip_o), 8'h00);

    // R1 R2 year wrap, BCD 24h
    upd_en = 1;
    load_time(59, 59, 23, 6, 31, 12, 99);
    do_tick("R1");
    chk("R1", "wday wraps", wday_o, 8'h00);
    chk("R2", "year wraps", year_o, 8'h00);
    chk("R3", "bcd month", mon_o, 8'h01);

    // R2 leap / non-leap / invalid month, binary
    bin = 1;
    load_time(59, 59, 23, 1, 28, 2, 24);
    do_tick("R2");
    chk("R2", "leap feb 29", mday_o, 8'd29);
    load_time(59, 59, 23, 1, 28, 2, 23);
    do_tick("R2");
    chk("R2", "non-leap mar 1", mon_o, 8'd3);
    load_time(59, 59, 23, 1, 31, 13, 40);
    do_tick("R2");
    chk("R2", "invalid month wraps", mon_o, 8'd1);
    chk("R3", "binary year", year_o, 8'd41);

    // R4 12-hour PM transition, BCD
    bin = 0; h24 = 0;
    load_time(59, 59, 11, 2, 10, 5, 30);
    do_tick("R4");
    chk("R4", "noon is pm zero", hour_o, 8'h80);
    load_time(59, 59, 21, 2, 10, 5, 30);
    do_tick("R4");
    chk("R4", "10 pm bcd", hour_o, 8'h90);
    h24 = 1;

    // R5 gate
    osc = 3'b000;
    do_tick("R5");
    chk("R5", "sec held when gated", sec_o, m_d[0]);
    osc = 3'b010;

    // R7 freeze, R8 write under freeze loads on release
    set_on();
    do_tick("R7");
    host_wr(1, 8'h45);
    chk("R8", "min written in freeze", min_o, 8'h45);
    set_off();
    do_tick("R8");
    chk("R8", "min kept after release", min_o, 8'h45);
    host_wr(0, 8'h30);
    host_wr(7, 8'h12);
    do_tick("R8");
    chk("R8", "direct write counts on", sec_o, 8'h31);

    // R9 alarm
    alm_en = 1; upd_en = 0;
    load_time(10, 20, 5, 3, 4, 6, 50);
    a_sec = 8'h11; a_min = 8'hC0; a_hour = 8'hFF;
    do_tick("R9");
    chk("R9", "alarm with dont care", flags_o, 8'h00);
    a_sec = 8'h12; a_min = 8'h21; a_hour = 8'h05;
    do_tick("R9");
    a_sec = 8'h13; a_min = 8'h20; upd_en = 1;
    do_tick("R9");

    // random
    for (int it = 0; it < 150; it++) begin
      int s, mi, h, wd, md, mo, y, nt;
      bin = $urandom % 2; h24 = $urandom % 2;
      alm_en = $urandom % 2; upd_en = $urandom % 2;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      wd = $urandom % 7; mo = 1 + $urandom % 12;
      y  = ($urandom % 3 == 0) ? 99 : $urandom % 100;
      md = ($urandom % 2) ? f_dim(mo, y) : 1 + $urandom % f_dim(mo, y);
      load_time(s, mi, h, wd, md, mo, y);
      nt = 1 + $urandom % 3;
      for (int k = 0; k < nt; k++) begin
        osc = ($urandom % 5 == 0) ? 3'b110 : 3'b010;
        a_sec  = ($urandom % 4 == 0) ? 8'hC3 : f_enc((m_t[0] + 1) % 60, bin);
        a_min  = ($urandom % 2) ? 8'hC0 : f_enc(m_t[1], bin);
        a_hour = ($urandom % 2) ? 8'hFF : f_enc(m_t[2], bin);
        do_tick("R1");
      end
      osc = 3'b010;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule